// File: doc/BRIEF.md
# Network Controller Sleep-Mode Sequencer

This block decides when a network controller on a PCI-style bus goes to sleep and when it wakes up again. An active-low sleep input asks for a low-power state. A mode-select bit picks one of two states. Deep sleep (coma) turns off receive and link indication. Wake-capable sleep (snooze) keeps the receive path and the link-status LED alive, so that network activity can be used to drive the sleep input high again. Snooze is only granted when the twisted-pair port is selected. Otherwise the block falls back to coma.

Before it sleeps, the block finishes any bus request that is still outstanding. It keeps the request asserted until the grant arrives and only then drops it. Next it spends exactly one cycle issuing an internal soft-reset pulse, and then it enters the chosen state. While the block is in the reset or sleep states, I/O target accesses end in a target abort. Configuration-space accesses are still acknowledged. Link beat transmission stops, and the activity LEDs go dark. A sleep request is ignored for the first three clocks after the hardware reset is released.

Top module: `sleep_seq`

## Requirements
- R1: With the guard window over and no bus request pending, a low `sleepN` moves the state from RUN to RESET at the next clock edge and to the selected sleep state one edge later. `snoozeSel`=0 selects COMA and `snoozeSel`=1 selects SNOOZE. `stateOneHot` uses these encodings: bit0 RUN, bit1 WAIT_GNT, bit2 RESET, bit3 COMA, bit4 SNOOZE.
- R2: While `rstN` is low, the state is RUN, `busReq` follows `busReqIn`, `rxEnable` and `linkBeatTx` are 1, and `actLedOut` is 0.
- R3: If `busReqIn` is high when sleep is accepted, the state becomes WAIT_GNT with `busReq`=1. It stays there while `busGnt` is low. The edge that samples `busGnt` high moves the state to RESET with `busReq`=0.
- R4: `softRst` is 1 exactly in the single cycle spent in RESET, and every sleep entry passes through RESET.
- R5: During RESET, COMA or SNOOZE, an `ioAccess` gives `ioAbort`=1 and `ioAck`=0. In RUN and WAIT_GNT it gives `ioAck`=1 and `ioAbort`=0. `cfgAck` equals `cfgAccess` in every state.
- R6: `rxEnable` is 1 in RUN, WAIT_GNT and SNOOZE, and 0 in RESET and COMA. `linkLedOut` = `rxEnable` & `linkLedEn` & `linkPulseIn`.
- R7: `linkBeatTx` is 0 in RESET, COMA and SNOOZE, and 1 in RUN and WAIT_GNT.
- R8: If snooze is selected while `tpSelected` is 0, the RESET state is followed by COMA.
- R9: A low `sleepN` has no effect at the first three rising edges after `rstN` goes high. It can first take effect at the fourth edge.
- R10: From COMA or SNOOZE, a high `sleepN` returns the state to RUN at the next edge. `actLedOut` is registered: after each edge it equals `actLedIn` if the state before the edge was RUN or WAIT_GNT, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low |
| sleepN | input | 1 | Sleep request, active low |
| snoozeSel | input | 1 | Mode select: 0 coma, 1 snooze |
| tpSelected | input | 1 | Twisted-pair port is the selected network port |
| linkLedEn | input | 1 | Enables the link-status indication |
| busReqIn | input | 1 | Bus request from the controller core |
| busGnt | input | 1 | Bus grant |
| busReq | output | 1 | Bus request to the bus |
| ioAccess | input | 1 | An I/O target access is presented |
| ioAbort | output | 1 | Terminate the I/O access with target abort |
| ioAck | output | 1 | Complete the I/O access normally |
| cfgAccess | input | 1 | A configuration-space access is presented |
| cfgAck | output | 1 | Complete the configuration access |
| linkPulseIn | input | 1 | Link beat or valid frame seen by the receiver |
| linkLedOut | output | 1 | Link-status LED |
| actLedIn | input | ACT_W | Other LED indications from the core |
| actLedOut | output | ACT_W | Other LED outputs, dark while asleep |
| rxEnable | output | 1 | Receive circuitry enable |
| linkBeatTx | output | 1 | Link beat transmit enable |
| softRst | output | 1 | Internal soft-reset pulse |
| stateOneHot | output | 5 | One-hot state |

## Verification
A wrong state register shows up at the ports in the same cycle, because `stateOneHot`, `ioAbort`, `rxEnable` and `linkBeatTx` are all decoded from it. So the bench compares the full output vector after every clock edge. A lost grant wait appears as `busReq` dropping while `busGnt` is still low. A skipped reset appears as a sleep state with no preceding `softRst` cycle. Errors in the registered activity LEDs appear one edge later, and the bench expects them at that edge.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
  localparam int STATE_COUNT = 5;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_WAIT_GNT = 3'd1,
    ST_RESET    = 3'd2,
    ST_COMA     = 3'd3,
    ST_SNOOZE   = 3'd4
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic awake;    // RUN or WAIT_GNT
    logic rxAlive;  // receive path powered
    logic softRst;  // one-cycle internal reset
    logic asleep;   // RESET, COMA or SNOOZE
  } seqStrobe_t;
endpackage

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_seq_pkg::*;
#(
  parameter int GUARD_CYCLES = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sleepN,
  input  logic                   snoozeSel,
  input  logic                   tpSelected,
  input  logic                   busReqIn,
  input  logic                   busGnt,
  output logic                   busReq,
  output seqStrobe_t             strobe,
  output logic [STATE_COUNT-1:0] stateOneHot
);
  localparam int CW = $clog2(GUARD_CYCLES + 1);

  seqState_t stateQ, stateD;
  logic [CW-1:0] guardCnt;
  logic guardDone;
  logic sleepReq;

  assign guardDone = (guardCnt == CW'(GUARD_CYCLES));
  assign sleepReq  = !sleepN && guardDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) guardCnt <= '0;
    else if (!guardDone) guardCnt <= guardCnt + 1'b1;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_RUN:      if (sleepReq) stateD = busReqIn ? ST_WAIT_GNT : ST_RESET;
      ST_WAIT_GNT: if (busGnt) stateD = ST_RESET;
      ST_RESET:    stateD = (snoozeSel && tpSelected) ? ST_SNOOZE : ST_COMA;
      ST_COMA,
      ST_SNOOZE:   if (sleepN) stateD = ST_RUN;
      default:     stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

  for (genvar i = 0; i < STATE_COUNT; i++) begin : g_oneHot
    assign stateOneHot[i] = (stateQ == seqState_t'(i));
  end

  always_comb begin
    strobe.awake   = (stateQ == ST_RUN) || (stateQ == ST_WAIT_GNT);
    strobe.rxAlive = strobe.awake || (stateQ == ST_SNOOZE);
    strobe.softRst = (stateQ == ST_RESET);
    strobe.asleep  = !strobe.awake;
    unique case (stateQ)
      ST_RUN:      busReq = busReqIn;
      ST_WAIT_GNT: busReq = 1'b1;
      default:     busReq = 1'b0;
    endcase
  end

  logic asleepState;
  assign asleepState = (stateQ == ST_COMA) || (stateQ == ST_SNOOZE);

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stateOneHot) == 1); // R1
  AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !guardDone |=> stateQ == ST_RUN); // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT_GNT && !busGnt) |=> (stateQ == ST_WAIT_GNT && busReq)); // R3
  AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asleepState) |-> $past(stateQ) == ST_RESET); // R4
  AST_SNOOZE_NEEDS_TP: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RESET && !tpSelected) |=> stateQ == ST_COMA); // R8
  AST_WAKE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (asleepState && sleepN) |=> stateQ == ST_RUN); // R10
endmodule

// File: rtl/sleep_dpath.sv
module sleep_dpath
  import sleep_seq_pkg::*;
#(
  parameter int ACT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             ioAccess,
  input  logic             cfgAccess,
  input  logic             linkLedEn,
  input  logic             linkPulseIn,
  input  logic [ACT_W-1:0] actLedIn,
  output logic             ioAbort,
  output logic             ioAck,
  output logic             cfgAck,
  output logic             rxEnable,
  output logic             linkBeatTx,
  output logic             linkLedOut,
  output logic [ACT_W-1:0] actLedOut
);
  logic [ACT_W-1:0] actQ;

  assign ioAbort    = ioAccess && strobe.asleep;
  assign ioAck      = ioAccess && strobe.awake;
  assign cfgAck     = cfgAccess;
  assign rxEnable   = strobe.rxAlive;
  assign linkBeatTx = strobe.awake;
  assign linkLedOut = strobe.rxAlive && linkLedEn && linkPulseIn;
  assign actLedOut  = actQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              actQ <= '0;
    else if (strobe.softRst || !strobe.awake) actQ <= '0;
    else                                    actQ <= actLedIn;
  end

  AST_ABORT_OR_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ioAccess |-> (ioAbort != ioAck)); // R5
  AST_LINK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    linkLedOut |-> (linkLedEn && rxEnable)); // R6
  AST_ACT_DARK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.asleep |=> actLedOut == '0); // R10
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int ACT_W        = 2,
  parameter int GUARD_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepN,
  input  logic             snoozeSel,
  input  logic             tpSelected,
  input  logic             linkLedEn,
  input  logic             busReqIn,
  input  logic             busGnt,
  output logic             busReq,
  input  logic             ioAccess,
  output logic             ioAbort,
  output logic             ioAck,
  input  logic             cfgAccess,
  output logic             cfgAck,
  input  logic             linkPulseIn,
  output logic             linkLedOut,
  input  logic [ACT_W-1:0] actLedIn,
  output logic [ACT_W-1:0] actLedOut,
  output logic             rxEnable,
  output logic             linkBeatTx,
  output logic             softRst,
  output logic [4:0]       stateOneHot
);
  seqStrobe_t strobe;

  sleep_ctrl #(.GUARD_CYCLES(GUARD_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sleepN(sleepN), .snoozeSel(snoozeSel),
    .tpSelected(tpSelected), .busReqIn(busReqIn), .busGnt(busGnt),
    .busReq(busReq), .strobe(strobe), .stateOneHot(stateOneHot)
  );

  sleep_dpath #(.ACT_W(ACT_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ioAccess(ioAccess),
    .cfgAccess(cfgAccess), .linkLedEn(linkLedEn), .linkPulseIn(linkPulseIn),
    .actLedIn(actLedIn), .ioAbort(ioAbort), .ioAck(ioAck), .cfgAck(cfgAck),
    .rxEnable(rxEnable), .linkBeatTx(linkBeatTx), .linkLedOut(linkLedOut),
    .actLedOut(actLedOut)
  );

  assign softRst = strobe.softRst;

  AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !softRst); // R4
endmodule

// File: tb/sleep_seq_tb_top.sv
`timescale 1ns/100ps
module sleep_seq_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepN = 1'b1, snoozeSel = 1'b0, tpSelected = 1'b1, linkLedEn = 1'b0;
  logic busReqIn = 1'b0, busGnt = 1'b0, ioAccess = 1'b0, cfgAccess = 1'b0;
  logic linkPulseIn = 1'b0;
  logic [1:0] actLedIn = 2'b00;
  logic busReq, ioAbort, ioAck, cfgAck, linkLedOut, rxEnable, linkBeatTx, softRst;
  logic [1:0] actLedOut;
  logic [4:0] stateOneHot;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [4:0] S_RUN = 5'b00001, S_WAIT = 5'b00010, S_RST = 5'b00100,
                         S_COMA = 5'b01000, S_SNZ = 5'b10000;

  always #2.5 clk = ~clk;

  sleep_seq dut_i (
    .clk(clk), .rstN(rstN), .sleepN(sleepN), .snoozeSel(snoozeSel),
    .tpSelected(tpSelected), .linkLedEn(linkLedEn), .busReqIn(busReqIn),
    .busGnt(busGnt), .busReq(busReq), .ioAccess(ioAccess), .ioAbort(ioAbort),
    .ioAck(ioAck), .cfgAccess(cfgAccess), .cfgAck(cfgAck),
    .linkPulseIn(linkPulseIn), .linkLedOut(linkLedOut), .actLedIn(actLedIn),
    .actLedOut(actLedOut), .rxEnable(rxEnable), .linkBeatTx(linkBeatTx),
    .softRst(softRst), .stateOneHot(stateOneHot)
  );

  // Observed vector: {state, req, abort, ack, srst, rx, beat, lnk, act[1:0]}
  logic [13:0] expQ[$];
  string tagQ[$];

  function automatic logic [13:0] observed();
    return {stateOneHot, busReq, ioAbort, ioAck, softRst, rxEnable,
            linkBeatTx, linkLedOut, actLedOut};
  endfunction

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Monitor: compare after every edge once an item is queued
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) check(tagQ.pop_front(), observed(), expQ.pop_front());
  end

  // Driver: queue the value expected after the next edge, then advance
  task automatic step(input logic [4:0] st, input logic req, abort, ack, srst,
                      rx, beat, lnk, input logic [1:0] act, input string tag);
    expQ.push_back({st, req, abort, ack, srst, rx, beat, lnk, act});
    tagQ.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    cfgAccess = 1'b1;
    busReqIn = 1'b1;
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 reset state", observed(), {S_RUN, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00});
    check("R5 cfg in reset", {13'd0, cfgAck}, 14'd1);
    busReqIn = 1'b0;
    // R9 guard window then R1 coma entry
    rstN = 1'b1; sleepN = 1'b0; actLedIn = 2'b10;
    step(S_RUN, 0,0,0,0,1,1,0,2'b10, "R9 guard edge1");
    step(S_RUN, 0,0,0,0,1,1,0,2'b10, "R9 guard edge2");
    step(S_RUN, 0,0,0,0,1,1,0,2'b10, "R9 guard edge3");
    step(S_RST, 0,0,0,1,0,0,0,2'b10, "R4 reset pulse");
    step(S_COMA,0,0,0,0,0,0,0,2'b00, "R1 coma entered");
    ioAccess = 1'b1; linkLedEn = 1'b1; linkPulseIn = 1'b1;
    step(S_COMA,0,1,0,0,0,0,0,2'b00, "R5 R6 coma abort, link dark");
    check("R5 cfg while coma", {13'd0, cfgAck}, 14'd1);
    // R10 wake
    sleepN = 1'b1;
    step(S_RUN, 0,0,1,0,1,1,1,2'b00, "R10 wake to run");
    step(S_RUN, 0,0,1,0,1,1,1,2'b10, "R10 act led resumes");
    // Snooze
    snoozeSel = 1'b1; tpSelected = 1'b1; sleepN = 1'b0; ioAccess = 1'b0;
    step(S_RST, 0,0,0,1,0,0,0,2'b10, "R4 reset before snooze");
    step(S_SNZ, 0,0,0,0,1,0,1,2'b00, "R1 R6 R7 snooze link alive");
    linkPulseIn = 1'b0;
    step(S_SNZ, 0,0,0,0,1,0,0,2'b00, "R6 no pulse");
    linkPulseIn = 1'b1; linkLedEn = 1'b0;
    step(S_SNZ, 0,0,0,0,1,0,0,2'b00, "R6 enable bit clear");
    ioAccess = 1'b1;
    step(S_SNZ, 0,1,0,0,1,0,0,2'b00, "R5 snooze abort");
    check("R5 cfg while snooze", {13'd0, cfgAck}, 14'd1);
    sleepN = 1'b1;
    step(S_RUN, 0,0,1,0,1,1,0,2'b00, "R10 wake from snooze");
    step(S_RUN, 0,0,1,0,1,1,0,2'b10, "R10 act after snooze");
    // R3 bus handshake
    ioAccess = 1'b0; busReqIn = 1'b1; sleepN = 1'b0; snoozeSel = 1'b0;
    step(S_WAIT,1,0,0,0,1,1,0,2'b10, "R3 wait for grant");
    step(S_WAIT,1,0,0,0,1,1,0,2'b10, "R3 request held");
    busGnt = 1'b1;
    step(S_RST, 0,0,0,1,0,0,0,2'b10, "R3 grant then reset");
    busGnt = 1'b0;
    step(S_COMA,0,0,0,0,0,0,0,2'b00, "R1 coma after handshake");
    sleepN = 1'b1;
    step(S_RUN, 1,0,0,0,1,1,0,2'b00, "R2 request follows core");
    busReqIn = 1'b0;
    step(S_RUN, 0,0,0,0,1,1,0,2'b10, "R2 request released");
    // R8 fallback
    snoozeSel = 1'b1; tpSelected = 1'b0; sleepN = 1'b0;
    step(S_RST, 0,0,0,1,0,0,0,2'b10, "R8 reset");
    step(S_COMA,0,0,0,0,0,0,0,2'b00, "R8 coma fallback");
    sleepN = 1'b1;
    step(S_RUN, 0,0,0,0,1,1,0,2'b00, "R10 wake after fallback");
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule